// File: doc/BRIEF.md
# UART In-Band XON/XOFF Flow Control

This block adds software (in-band) flow control to a byte-wide UART data path. On the transmit side it sits between the transmit byte queue and the bit serializer. It chooses, at every frame boundary, whether the next byte handed to the serializer is a queued flow-control character or the next data byte. Flow-control characters are queued in two ways. The first is automatic: the receive fill level rises above one programmable threshold, or falls back to or below a second one. The second is a single-cycle software request pulse.

On the receive side it watches each byte from the deserializer. Bytes equal to the programmed pause or resume codes are removed from the stream. Such a byte stops or restarts the fetching of transmit data, and sets a sticky interrupt flag. A single enable input gates all of this. When the enable is clear, the block is a plain pass-through in both directions. The serializer, the deserializer and both FIFOs are outside the block and appear as simple byte handshakes.

Top module: `uswf_top`

## Requirements
- R1: While `cfg_en` is 0, transmit bytes pass from `txq_*` to `ser_*` unchanged. No flow-control character is emitted, whatever the software requests or `rx_level` do. Every received byte is forwarded, including bytes equal to a flow code. `irq_flag` does not get set.
- R2: While enabled, when `rx_level` is strictly greater than `cfg_xoff_lvl`, exactly one pause character is queued. No further one is queued until the level has fallen back as in R3.
- R3: After an automatic pause character, when `rx_level` drops to or below `cfg_xon_lvl`, exactly one resume character is queued. A level between the two thresholds queues nothing.
- R4: A one-cycle pulse on `sw_send_xoff` while enabled results in exactly one pause character. A byte moves to the serializer only in a cycle where `ser_valid` and `ser_ready` are both 1, and `ser_ready` is 1 only once the previous frame has finished. The character therefore follows the frame in flight and never splits it. `txq_ready` is never 1 while `ser_ready` is 0.
- R5: A one-cycle pulse on `sw_send_xon` while enabled results in exactly one resume character. It is sent after the frame in flight, in the same way as R4.
- R6: At a frame boundary, the order of priority is: a pending pause character first, then a pending resume character, then data. A data byte is fetched (`txq_valid && txq_ready`) in the same cycle that it appears on `ser_data`.
- R7: A received byte equal to `cfg_xoff_char` stops data fetching after the current frame, so `txq_ready` stays 0. Flow-control characters are still sent during the stop. A received `cfg_xon_char` lets data flow again.
- R8: While enabled, a received byte equal to either flow code is consumed, so `rxq_valid` stays 0. Every other byte appears on `rxq_valid`/`rxq_data` in the same cycle, unchanged.
- R9: `irq_flag[0]` records a received resume code and `irq_flag[1]` records a received pause code. A flag is set one cycle after the byte, and only if the matching `irq_en` bit is 1. A flag stays set until a one-cycle pulse on the matching `irq_clr` bit. If a set and a clear arrive in the same cycle, the set wins.
- R10: The two character codes are taken from `cfg_xon_char` and `cfg_xoff_char` at the moment of use, for both sending and matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Flow-control enable |
| cfg_xon_char | input | CHAR_W | Resume character code |
| cfg_xoff_char | input | CHAR_W | Pause character code |
| cfg_xoff_lvl | input | LVL_W | Receive level above which a pause is sent |
| cfg_xon_lvl | input | LVL_W | Receive level at or below which a resume is sent |
| sw_send_xon | input | 1 | Software request pulse: send resume |
| sw_send_xoff | input | 1 | Software request pulse: send pause |
| rx_level | input | LVL_W | Receive FIFO fill count |
| rx_valid | input | 1 | Byte from the deserializer |
| rx_data | input | CHAR_W | Received byte |
| rxq_valid | output | 1 | Write strobe to the receive FIFO |
| rxq_data | output | CHAR_W | Byte written to the receive FIFO |
| txq_valid | input | 1 | Transmit FIFO not empty |
| txq_data | input | CHAR_W | Head byte of the transmit FIFO |
| txq_ready | output | 1 | Pop strobe for the transmit FIFO |
| ser_valid | output | 1 | Byte offered to the serializer |
| ser_data | output | CHAR_W | Byte offered to the serializer |
| ser_ready | input | 1 | Serializer idle, frame boundary |
| irq_en | input | 2 | Per-flag interrupt enables |
| irq_clr | input | 2 | Write-one-to-clear pulses |
| irq_flag | output | 2 | Sticky flags: bit0 resume received, bit1 pause received |

## Verification
Each software request is raised while a data frame is known to be in flight. This shows whether the character waits for the boundary and is then sent ahead of the remaining data. Both requests are also raised together, which exposes the order of priority. The receive level is moved below, between and above the two thresholds, and then across them a second time. This tells a single queued character per crossing apart from repeated or missing ones. Received pause and resume bytes are combined with masked and unmasked flags, with the enable cleared, and with changed character codes. These cases separate the stopping of data, the filtering of the bytes and the flag behaviour.

// File: rtl/uswf_pkg.sv
package uswf_pkg;

   localparam int IRQ_N    = 2;
   localparam int IRQ_XON  = 0;
   localparam int IRQ_XOFF = 1;

   typedef enum logic [1:0] {
      SRC_IDLE = 2'd0,
      SRC_XOFF = 2'd1,
      SRC_XON  = 2'd2,
      SRC_DATA = 2'd3
   } uswf_src_e;

endpackage

// File: rtl/uswf_rx_filter.sv
module uswf_rx_filter #(
   parameter int CHAR_W = 8
) (
   input  logic              en,
   input  logic              rx_valid,
   input  logic [CHAR_W-1:0] rx_data,
   input  logic [CHAR_W-1:0] xon_char,
   input  logic [CHAR_W-1:0] xoff_char,
   output logic              fwd_valid,
   output logic [CHAR_W-1:0] fwd_data,
   output logic              hit_xon,
   output logic              hit_xoff
);

   logic match_on, match_off;

   always_comb begin
      match_off = rx_data == xoff_char;
      match_on  = (rx_data == xon_char) && !match_off;
      hit_xoff  = en && rx_valid && match_off;
      hit_xon   = en && rx_valid && match_on;
      fwd_valid = rx_valid && !(hit_xoff || hit_xon);
      fwd_data  = rx_data;
   end

endmodule

// File: rtl/uswf_req_ctrl.sv
module uswf_req_ctrl #(
   parameter int LVL_W   = 7,
   parameter bit AUTO_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             sw_xon,
   input  logic             sw_xoff,
   input  logic [LVL_W-1:0] level,
   input  logic [LVL_W-1:0] xoff_lvl,
   input  logic [LVL_W-1:0] xon_lvl,
   input  logic             sent_xon,
   input  logic             sent_xoff,
   output logic             pend_xon,
   output logic             pend_xoff
);

   logic auto_off, auto_on;

   generate
      if (AUTO_EN) begin : g_auto
         logic held;
         always_comb begin
            auto_off = en && !held && (level > xoff_lvl);
            auto_on  = en &&  held && (level <= xon_lvl);
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        held <= 1'b0;
            else if (!en)      held <= 1'b0;
            else if (auto_off) held <= 1'b1;
            else if (auto_on)  held <= 1'b0;
         end
      end else begin : g_manual
         always_comb begin
            auto_off = 1'b0;
            auto_on  = 1'b0;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_xoff <= 1'b0;
         pend_xon  <= 1'b0;
      end else if (!en) begin
         pend_xoff <= 1'b0;
         pend_xon  <= 1'b0;
      end else begin
         pend_xoff <= (pend_xoff && !sent_xoff) || sw_xoff || auto_off;
         pend_xon  <= (pend_xon  && !sent_xon)  || sw_xon  || auto_on;
      end
   end

endmodule

// File: rtl/uswf_tx_arb.sv
module uswf_tx_arb
   import uswf_pkg::*;
#(
   parameter int CHAR_W     = 8,
   parameter bit XOFF_FIRST = 1'b1
) (
   input  logic              en,
   input  logic              pend_xon,
   input  logic              pend_xoff,
   input  logic              paused,
   input  logic [CHAR_W-1:0] xon_char,
   input  logic [CHAR_W-1:0] xoff_char,
   input  logic              txq_valid,
   input  logic [CHAR_W-1:0] txq_data,
   input  logic              ser_ready,
   output logic              txq_ready,
   output logic              ser_valid,
   output logic [CHAR_W-1:0] ser_data,
   output logic              sent_xon,
   output logic              sent_xoff
);

   uswf_src_e src;
   logic      flow_busy, data_ok;

   always_comb begin
      flow_busy = en && (pend_xoff || pend_xon);
      data_ok   = !(en && paused);
   end

   generate
      if (XOFF_FIRST) begin : g_xoff_first
         always_comb begin
            if (en && pend_xoff)           src = SRC_XOFF;
            else if (en && pend_xon)       src = SRC_XON;
            else if (txq_valid && data_ok) src = SRC_DATA;
            else                           src = SRC_IDLE;
         end
      end else begin : g_xon_first
         always_comb begin
            if (en && pend_xon)            src = SRC_XON;
            else if (en && pend_xoff)      src = SRC_XOFF;
            else if (txq_valid && data_ok) src = SRC_DATA;
            else                           src = SRC_IDLE;
         end
      end
   endgenerate

   always_comb begin
      case (src)
         SRC_XOFF: ser_data = xoff_char;
         SRC_XON:  ser_data = xon_char;
         SRC_DATA: ser_data = txq_data;
         default:  ser_data = '0;
      endcase
      ser_valid = src != SRC_IDLE;
      txq_ready = ser_ready && !flow_busy && data_ok;
      sent_xoff = ser_ready && (src == SRC_XOFF);
      sent_xon  = ser_ready && (src == SRC_XON);
   end

endmodule

// File: rtl/uswf_irq.sv
module uswf_irq #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] ev,
   input  logic [N-1:0] mask,
   input  logic [N-1:0] clr,
   output logic [N-1:0] flag
);

   generate
      for (genvar i = 0; i < N; i++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 flag[i] <= 1'b0;
            else if (ev[i] && mask[i])  flag[i] <= 1'b1;
            else if (clr[i])            flag[i] <= 1'b0;
         end
      end
   endgenerate

endmodule

// File: rtl/uswf_top.sv
module uswf_top
   import uswf_pkg::*;
#(
   parameter int CHAR_W     = 8,
   parameter int RX_DEPTH   = 64,
   parameter bit AUTO_EN    = 1'b1,
   parameter bit XOFF_FIRST = 1'b1,
   localparam int LVL_W     = $clog2(RX_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_en,
   input  logic [CHAR_W-1:0] cfg_xon_char,
   input  logic [CHAR_W-1:0] cfg_xoff_char,
   input  logic [LVL_W-1:0]  cfg_xoff_lvl,
   input  logic [LVL_W-1:0]  cfg_xon_lvl,
   input  logic              sw_send_xon,
   input  logic              sw_send_xoff,
   input  logic [LVL_W-1:0]  rx_level,
   input  logic              rx_valid,
   input  logic [CHAR_W-1:0] rx_data,
   output logic              rxq_valid,
   output logic [CHAR_W-1:0] rxq_data,
   input  logic              txq_valid,
   input  logic [CHAR_W-1:0] txq_data,
   output logic              txq_ready,
   output logic              ser_valid,
   output logic [CHAR_W-1:0] ser_data,
   input  logic              ser_ready,
   input  logic [IRQ_N-1:0]  irq_en,
   input  logic [IRQ_N-1:0]  irq_clr,
   output logic [IRQ_N-1:0]  irq_flag
);

   if (CHAR_W < 5 || CHAR_W > 9) begin : g_bad_char_w
      $error("uswf_top: CHAR_W must lie in 5..9");
   end
   if (RX_DEPTH < 2) begin : g_bad_depth
      $error("uswf_top: RX_DEPTH must be at least 2");
   end

   logic             hit_xon, hit_xoff;
   logic             pend_xon, pend_xoff;
   logic             sent_xon, sent_xoff;
   logic             paused;
   logic [IRQ_N-1:0] irq_ev;

   uswf_rx_filter #(.CHAR_W(CHAR_W)) u_rx (
      .en        (cfg_en),
      .rx_valid  (rx_valid),
      .rx_data   (rx_data),
      .xon_char  (cfg_xon_char),
      .xoff_char (cfg_xoff_char),
      .fwd_valid (rxq_valid),
      .fwd_data  (rxq_data),
      .hit_xon   (hit_xon),
      .hit_xoff  (hit_xoff)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        paused <= 1'b0;
      else if (!cfg_en)  paused <= 1'b0;
      else if (hit_xoff) paused <= 1'b1;
      else if (hit_xon)  paused <= 1'b0;
   end

   uswf_req_ctrl #(.LVL_W(LVL_W), .AUTO_EN(AUTO_EN)) u_req (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (cfg_en),
      .sw_xon    (sw_send_xon),
      .sw_xoff   (sw_send_xoff),
      .level     (rx_level),
      .xoff_lvl  (cfg_xoff_lvl),
      .xon_lvl   (cfg_xon_lvl),
      .sent_xon  (sent_xon),
      .sent_xoff (sent_xoff),
      .pend_xon  (pend_xon),
      .pend_xoff (pend_xoff)
   );

   uswf_tx_arb #(.CHAR_W(CHAR_W), .XOFF_FIRST(XOFF_FIRST)) u_arb (
      .en        (cfg_en),
      .pend_xon  (pend_xon),
      .pend_xoff (pend_xoff),
      .paused    (paused),
      .xon_char  (cfg_xon_char),
      .xoff_char (cfg_xoff_char),
      .txq_valid (txq_valid),
      .txq_data  (txq_data),
      .ser_ready (ser_ready),
      .txq_ready (txq_ready),
      .ser_valid (ser_valid),
      .ser_data  (ser_data),
      .sent_xon  (sent_xon),
      .sent_xoff (sent_xoff)
   );

   always_comb begin
      irq_ev           = '0;
      irq_ev[IRQ_XON]  = hit_xon;
      irq_ev[IRQ_XOFF] = hit_xoff;
   end

   uswf_irq #(.N(IRQ_N)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .ev    (irq_ev),
      .mask  (irq_en),
      .clr   (irq_clr),
      .flag  (irq_flag)
   );

endmodule

// File: rtl/uswf_chk.sv
module uswf_chk #(
   parameter int CHAR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_en,
   input logic [CHAR_W-1:0] cfg_xon_char,
   input logic [CHAR_W-1:0] cfg_xoff_char,
   input logic              rx_valid,
   input logic [CHAR_W-1:0] rx_data,
   input logic              rxq_valid,
   input logic [CHAR_W-1:0] rxq_data,
   input logic              txq_valid,
   input logic [CHAR_W-1:0] txq_data,
   input logic              txq_ready,
   input logic              ser_valid,
   input logic [CHAR_W-1:0] ser_data,
   input logic              ser_ready,
   input logic [1:0]        irq_clr,
   input logic [1:0]        irq_flag
);

   logic rx_is_flow, rx_is_on, rx_is_off;
   always_comb begin
      rx_is_off  = cfg_en && rx_valid && (rx_data == cfg_xoff_char);
      rx_is_on   = cfg_en && rx_valid && (rx_data == cfg_xon_char);
      rx_is_flow = rx_is_off || rx_is_on;
   end

   p_fetch_at_boundary_r4: assert property (@(posedge clk) disable iff (!rst_n)
      txq_ready |-> ser_ready);

   p_fetch_forwards_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (txq_valid && txq_ready) |-> (ser_valid && ser_data == txq_data));

   p_flow_consumed_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_is_flow |-> !rxq_valid);

   p_plain_forward_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !rx_is_flow) |-> (rxq_valid && rxq_data == rx_data));

   p_off_no_inject_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_en && ser_valid) |-> (txq_valid && ser_data == txq_data));

   p_on_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flag[0] && !irq_clr[0]) |=> irq_flag[0]);

   p_off_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flag[1] && !irq_clr[1]) |=> irq_flag[1]);

   p_off_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_clr[1] && !rx_is_off) |=> !irq_flag[1]);

   p_on_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_clr[0] && !rx_is_on) |=> !irq_flag[0]);

endmodule

bind uswf_top uswf_chk #(.CHAR_W(CHAR_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cfg_en        (cfg_en),
   .cfg_xon_char  (cfg_xon_char),
   .cfg_xoff_char (cfg_xoff_char),
   .rx_valid      (rx_valid),
   .rx_data       (rx_data),
   .rxq_valid     (rxq_valid),
   .rxq_data      (rxq_data),
   .txq_valid     (txq_valid),
   .txq_data      (txq_data),
   .txq_ready     (txq_ready),
   .ser_valid     (ser_valid),
   .ser_data      (ser_data),
   .ser_ready     (ser_ready),
   .irq_clr       (irq_clr),
   .irq_flag      (irq_flag)
);

// File: tb/uswf_top_tb.sv
`timescale 1ns/1ps
module uswf_top_tb;

   localparam int CW    = 8;
   localparam int LW    = 7;
   localparam int FRAME = 6;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          cfg_en;
   logic [CW-1:0] cfg_xon_char, cfg_xoff_char;
   logic [LW-1:0] cfg_xoff_lvl, cfg_xon_lvl, rx_level;
   logic          sw_send_xon, sw_send_xoff;
   logic          rx_valid;
   logic [CW-1:0] rx_data;
   logic          rxq_valid;
   logic [CW-1:0] rxq_data;
   logic          txq_valid;
   logic [CW-1:0] txq_data;
   logic          txq_ready;
   logic          ser_valid;
   logic [CW-1:0] ser_data;
   logic          ser_ready;
   logic [1:0]    irq_en, irq_clr, irq_flag;

   always #2.5 clk = ~clk;

   uswf_top u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en),
      .cfg_xon_char(cfg_xon_char), .cfg_xoff_char(cfg_xoff_char),
      .cfg_xoff_lvl(cfg_xoff_lvl), .cfg_xon_lvl(cfg_xon_lvl),
      .sw_send_xon(sw_send_xon), .sw_send_xoff(sw_send_xoff),
      .rx_level(rx_level), .rx_valid(rx_valid), .rx_data(rx_data),
      .rxq_valid(rxq_valid), .rxq_data(rxq_data),
      .txq_valid(txq_valid), .txq_data(txq_data), .txq_ready(txq_ready),
      .ser_valid(ser_valid), .ser_data(ser_data), .ser_ready(ser_ready),
      .irq_en(irq_en), .irq_clr(irq_clr), .irq_flag(irq_flag)
   );

   int n_cmp = 0;
   int n_bad = 0;
   int midframe = 0;
   int busy = 0;
   logic [CW-1:0] txq[$];
   logic [CW-1:0] got[$];
   logic [CW-1:0] exp_q[$];

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int expv);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   // transmit FIFO and serializer models; monitor of accepted bytes
   initial begin
      ser_ready = 1'b1; txq_valid = 1'b0; txq_data = '0;
      forever begin
         @(negedge clk);
         ser_ready = (busy == 0);
         txq_valid = txq.size() > 0;
         txq_data  = txq_valid ? txq[0] : '0;
         #1;
         if (txq_ready && !ser_ready) midframe++;
         if (ser_valid && ser_ready) begin
            got.push_back(ser_data);
            busy = FRAME;
         end else if (busy > 0) begin
            busy--;
         end
         if (txq_valid && txq_ready) void'(txq.pop_front());
      end
   end

   task automatic load_tx(input logic [CW-1:0] b); txq.push_back(b); endtask
   task automatic expect_b(input logic [CW-1:0] b); exp_q.push_back(b); endtask

   task automatic sb_check(input string req);
      int waited = 0;
      while (got.size() < exp_q.size() && waited < 500) begin
         @(negedge clk); waited++;
      end
      repeat (30) @(negedge clk);
      #2;
      chk(got.size() == exp_q.size(), req, "byte count", got.size(), exp_q.size());
      while (got.size() > 0 && exp_q.size() > 0) begin
         logic [CW-1:0] a, e;
         a = got.pop_front(); e = exp_q.pop_front();
         chk(a == e, req, "serializer byte", a, e);
      end
      got.delete(); exp_q.delete();
   endtask

   task automatic wait_got(input int n);
      int w = 0;
      while (got.size() < n && w < 500) begin
         @(negedge clk); #2; w++;
      end
   endtask

   task automatic pulse_xon();
      @(negedge clk); sw_send_xon = 1'b1; @(negedge clk); sw_send_xon = 1'b0;
   endtask
   task automatic pulse_xoff();
      @(negedge clk); sw_send_xoff = 1'b1; @(negedge clk); sw_send_xoff = 1'b0;
   endtask
   task automatic pulse_clr(input logic [1:0] m);
      @(negedge clk); irq_clr = m; @(negedge clk); irq_clr = 2'b00;
   endtask

   task automatic rx_byte(input logic [CW-1:0] b, input bit fwd, input string req);
      @(negedge clk); rx_valid = 1'b1; rx_data = b; #1;
      chk(rxq_valid == fwd, req, "rxq_valid", rxq_valid, fwd);
      if (fwd) chk(rxq_data == b, req, "rxq_data", rxq_data, b);
      @(negedge clk); rx_valid = 1'b0; #1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; cfg_en = 1'b0;
      cfg_xon_char = 8'h11; cfg_xoff_char = 8'h13;
      cfg_xoff_lvl = 7'd8; cfg_xon_lvl = 7'd4; rx_level = '0;
      sw_send_xon = 1'b0; sw_send_xoff = 1'b0;
      rx_valid = 1'b0; rx_data = '0;
      irq_en = 2'b11; irq_clr = 2'b00;
      repeat (4) @(negedge clk);
      #2;
      chk(ser_valid == 1'b0, "reset", "ser_valid", ser_valid, 0);
      chk(irq_flag == 2'b00, "reset", "irq_flag", irq_flag, 0);
      chk(rxq_valid == 1'b0, "reset", "rxq_valid", rxq_valid, 0);
      @(negedge clk); rst_n = 1'b1;

      // R1: disabled pass-through
      rx_level = 7'd60;
      load_tx(8'h13); load_tx(8'h11); load_tx(8'h42);
      expect_b(8'h13); expect_b(8'h11); expect_b(8'h42);
      pulse_xoff(); pulse_xon();
      rx_byte(8'h13, 1'b1, "R1");
      chk(irq_flag == 2'b00, "R1", "irq_flag", irq_flag, 0);
      sb_check("R1");
      rx_level = '0;
      @(negedge clk); cfg_en = 1'b1;

      // R4: software pause request during a data frame
      load_tx(8'h40); load_tx(8'h41); load_tx(8'h42); load_tx(8'h43);
      expect_b(8'h40); expect_b(8'h41); expect_b(8'h13); expect_b(8'h42); expect_b(8'h43);
      wait_got(2); pulse_xoff();
      sb_check("R4");

      // R5: software resume request during a data frame
      load_tx(8'h50); load_tx(8'h51); load_tx(8'h52);
      expect_b(8'h50); expect_b(8'h11); expect_b(8'h51); expect_b(8'h52);
      wait_got(1); pulse_xon();
      sb_check("R5");

      // R6: both pending at one boundary, pause first
      load_tx(8'h60); load_tx(8'h61);
      expect_b(8'h60); expect_b(8'h13); expect_b(8'h11); expect_b(8'h61);
      wait_got(1); pulse_xon(); pulse_xoff();
      sb_check("R6");

      // R7 / R8 / R9: received pause stops data, flow chars still go
      rx_byte(8'h13, 1'b0, "R8");
      chk(irq_flag == 2'b10, "R9", "irq_flag after pause byte", irq_flag, 2);
      load_tx(8'h70); load_tx(8'h71);
      repeat (40) @(negedge clk);
      #2;
      chk(got.size() == 0, "R7", "bytes sent while paused", got.size(), 0);
      chk(txq_ready == 1'b0, "R7", "txq_ready while paused", txq_ready, 0);
      expect_b(8'h11);
      pulse_xon();
      sb_check("R7");
      rx_byte(8'h11, 1'b0, "R8");
      expect_b(8'h70); expect_b(8'h71);
      sb_check("R7");
      chk(irq_flag == 2'b11, "R9", "irq_flag both", irq_flag, 3);
      rx_byte(8'h5C, 1'b1, "R8");
      pulse_clr(2'b10); #1;
      chk(irq_flag == 2'b01, "R9", "irq_flag after clear bit1", irq_flag, 1);
      pulse_clr(2'b01); #1;
      chk(irq_flag == 2'b00, "R9", "irq_flag after clear bit0", irq_flag, 0);
      irq_en = 2'b10;
      rx_byte(8'h11, 1'b0, "R8");
      chk(irq_flag == 2'b00, "R9", "masked resume flag", irq_flag, 0);
      rx_byte(8'h13, 1'b0, "R8");
      chk(irq_flag == 2'b10, "R9", "unmasked pause flag", irq_flag, 2);
      rx_byte(8'h11, 1'b0, "R8");
      pulse_clr(2'b10); irq_en = 2'b11;

      // R2 / R3: automatic thresholds
      @(negedge clk); rx_level = 7'd5;
      repeat (20) @(negedge clk);
      chk(got.size() == 0, "R2", "below threshold", got.size(), 0);
      rx_level = 7'd9; expect_b(8'h13);
      repeat (10) @(negedge clk);
      rx_level = 7'd12;
      sb_check("R2");
      rx_level = 7'd7;
      repeat (20) @(negedge clk);
      chk(got.size() == 0, "R3", "between thresholds", got.size(), 0);
      rx_level = 7'd4; expect_b(8'h11);
      sb_check("R3");
      rx_level = 7'd9; expect_b(8'h13);
      sb_check("R2");
      rx_level = 7'd0; expect_b(8'h11);
      sb_check("R3");

      // R10: new codes
      @(negedge clk); cfg_xon_char = 8'hA5; cfg_xoff_char = 8'h5A;
      expect_b(8'h5A);
      pulse_xoff();
      sb_check("R10");
      rx_byte(8'h13, 1'b1, "R10");
      rx_byte(8'h5A, 1'b0, "R10");
      chk(irq_flag == 2'b10, "R10", "irq_flag new pause code", irq_flag, 2);
      rx_byte(8'hA5, 1'b0, "R10");
      load_tx(8'h77); expect_b(8'h77);
      sb_check("R10");

      chk(midframe == 0, "R4", "fetches while serializer busy", midframe, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule